// File: doc/BRIEF.md
# Run-Length Prefix/Tail Test-Stream Decompressor

This block turns a serial stream of compressed test data into the scan bit stream it stands for. Each codeword describes a run of zeros closed by a single one. Runs are sorted into groups. Group j covers 2^j consecutive run lengths, starting at 2^j − 2. A codeword for group j has two parts. The first is a j-bit group marker: j−1 ones followed by a zero. The second is a j-bit offset within the group, sent most significant bit first. The run length is 2^j − 2 plus that offset.

A slow tester delivers one code bit at a time. It presents the bit and changes the level of a toggle line. The decompressor turns every level change into a one-cycle strobe and answers with a ready flag. On the fast side it emits at most one decoded bit per clock, qualified by a valid flag, straight into a scan chain. The tester clock boundary is modelled as this strobe inside a single clock domain.

The zeros of a run are emitted in two bursts. The base part of the group comes out right after the group marker. The offset part comes out right after the last offset bit. Ready is low only while zeros are being emitted.

Top module: `rlc_decomp`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `tst_ready` is 1 and `scan_valid` is 0.
- R2: A code bit is taken only when `tst_toggle` changes level while `tst_ready` is 1; `tst_bit` is sampled on the clock edge that follows the change. A steady `tst_toggle` produces no output, whatever `tst_bit` does.
- R3: A codeword is made of j−1 ones, then a zero, then j offset bits t (MSB first). It produces exactly 2^j − 2 + t zeros followed by one 1 on `scan_bit`, in order, for any sequence of codewords.
- R4: In every cycle, `tst_ready` is 0 exactly when `scan_valid` is 1 and `scan_bit` is 0.
- R5: After the edge that takes the zero closing the group marker, the block emits 2^j − 2 zeros in consecutive cycles before `tst_ready` rises again.
- R6: After the edge that takes the last offset bit, the block emits t zeros in consecutive cycles. The closing 1 is emitted in the cycle right after them, and `tst_ready` is 1 in that cycle.
- R7: Codeword `00` yields a lone 1 in the cycle after its second bit is taken. Codeword `01` yields one zero and then the 1.
- R8: `scan_valid` is 0 in every cycle that emits nothing, and a 1 is never emitted in two consecutive cycles.
- R9: The largest group, MAX_GROUP (default 10), decodes its full range, from 2^MAX_GROUP − 2 up to 2^(MAX_GROUP+1) − 3 zeros.
- R10: The first bit of the next codeword may be toggled in during the same cycle in which the closing 1 is emitted, and it is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tst_toggle | input | 1 | Tester strobe; every level change delivers one code bit |
| tst_bit | input | 1 | Code bit from the tester |
| tst_ready | output | 1 | High when the next code bit may be sent |
| scan_bit | output | 1 | Decoded scan data bit |
| scan_valid | output | 1 | Qualifies `scan_bit` in this cycle |

## Verification
The hardest situations to reach are the timing corners. One is a new codeword arriving in the very cycle the previous closing 1 leaves. Another is the longest run of the top group, which keeps the block busy for over a thousand cycles. The tester model in the bench can either toggle in the next bit at once on the closing-1 cycle or wait a random gap, so both orderings are reached. Directed codewords at the edges of the first and the last group are mixed with random run lengths, and a share of the random runs is drawn from the large groups.

// File: rtl/rlc_pkg.sv
// Shared types for the run-length decompressor.
// Assumes: one clock domain, counters driven by one-hot operation structs.
package rlc_pkg;

    typedef enum logic [2:0] {
        ST_HEAD,    // waiting for the first bit of a codeword
        ST_PREFIX,  // collecting further group-marker bits
        ST_PZERO,   // emitting the base zeros of the group
        ST_TAIL,    // collecting offset bits
        ST_TZERO    // emitting the offset zeros
    } rlc_state_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic shift;
        logic dec;
    } run_op_t;

    typedef struct packed {
        logic set1;
        logic set2;
        logic inc;
        logic dec;
    } grp_op_t;

endpackage

// File: rtl/rlc_toggle_detect.sv
// Turns every level change of the tester toggle into a one-cycle strobe.
// Assumes: the toggle is already synchronous to clk and is low at reset.
module rlc_toggle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tog,
    output logic strobe
);

    logic tog_q;

    // Remember last sampled toggle level.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog;
    end

    // A difference between now and last cycle is a new bit.
    assign strobe = tog ^ tog_q;

endmodule

// File: rtl/rlc_run_counter.sv
// Down-counter that also shifts in offset bits; counts zeros still to emit.
// Assumes: at most one operation is requested per cycle; CW >= 2.
module rlc_run_counter
    import rlc_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  run_op_t       op,
    input  logic [CW-1:0] load_val,
    input  logic          shift_bit,
    output logic          at_one,
    output logic          low_zero
);

    logic [CW-1:0] cnt;

    // Apply the requested counter operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (op.clr)   cnt <= '0;
        else if (op.load)  cnt <= load_val;
        else if (op.shift) cnt <= {cnt[CW-2:0], shift_bit};
        else if (op.dec)   cnt <= cnt - CW'(1);
    end

    // Last zero of the current burst.
    assign at_one   = (cnt == CW'(1));
    // Offset would be zero if the incoming bit is zero too.
    assign low_zero = (cnt[CW-2:0] == '0);

endmodule

// File: rtl/rlc_group_counter.sv
// Holds the group index while the marker is read, then counts offset bits down.
// Assumes: markers longer than MAX_GROUP saturate at MAX_GROUP.
module rlc_group_counter
    import rlc_pkg::*;
#(
    parameter int MAX_GROUP = 10,
    localparam int GW = $clog2(MAX_GROUP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  grp_op_t       op,
    output logic [GW-1:0] value,
    output logic          last
);

    logic [GW-1:0] grp;

    // Track the group index or the remaining offset bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       grp <= '0;
        else if (op.set1) grp <= GW'(1);
        else if (op.set2) grp <= GW'(2);
        else if (op.inc) begin
            if (grp < GW'(MAX_GROUP)) grp <= grp + GW'(1);
        end
        else if (op.dec)  grp <= grp - GW'(1);
    end

    assign value = grp;
    assign last  = (grp == GW'(1));

endmodule

// File: rtl/rlc_ctrl.sv
// Control FSM: parses marker and offset, sequences both zero bursts, emits the 1.
// Assumes: strobes arriving while busy are a tester protocol error and are dropped.
module rlc_ctrl
    import rlc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    strobe,
    input  logic    code_bit,
    input  logic    run_at_one,
    input  logic    run_low_zero,
    input  logic    grp_last,
    output run_op_t run_op,
    output grp_op_t grp_op,
    output logic    busy,
    output logic    one_out
);

    rlc_state_e state, state_nx;
    logic       one_q, one_nx;

    // Next-state and counter-operation decode.
    always_comb begin
        state_nx = state;
        one_nx   = 1'b0;
        run_op   = '0;
        grp_op   = '0;
        unique case (state)
            ST_HEAD: begin
                if (strobe) begin
                    if (code_bit) begin
                        grp_op.set2 = 1'b1;
                        state_nx    = ST_PREFIX;
                    end else begin
                        grp_op.set1 = 1'b1;
                        run_op.clr  = 1'b1;
                        state_nx    = ST_TAIL;
                    end
                end
            end
            ST_PREFIX: begin
                if (strobe) begin
                    if (code_bit) begin
                        grp_op.inc = 1'b1;
                    end else begin
                        run_op.load = 1'b1;
                        state_nx    = ST_PZERO;
                    end
                end
            end
            ST_PZERO: begin
                if (run_at_one) begin
                    run_op.clr = 1'b1;
                    state_nx   = ST_TAIL;
                end else begin
                    run_op.dec = 1'b1;
                end
            end
            ST_TAIL: begin
                if (strobe) begin
                    grp_op.dec   = 1'b1;
                    run_op.shift = 1'b1;
                    if (grp_last) begin
                        if (run_low_zero && !code_bit) begin
                            one_nx   = 1'b1;
                            state_nx = ST_HEAD;
                        end else begin
                            state_nx = ST_TZERO;
                        end
                    end
                end
            end
            ST_TZERO: begin
                run_op.dec = 1'b1;
                if (run_at_one) begin
                    one_nx   = 1'b1;
                    state_nx = ST_HEAD;
                end
            end
            default: state_nx = ST_HEAD;
        endcase
    end

    // State and closing-one registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HEAD;
            one_q <= 1'b0;
        end else begin
            state <= state_nx;
            one_q <= one_nx;
        end
    end

    assign busy    = (state == ST_PZERO) || (state == ST_TZERO);
    assign one_out = one_q;

endmodule

// File: rtl/rlc_decomp.sv
// Top level: tester strobe in, decoded scan bits out.
// Assumes: tester only toggles while tst_ready is high; MAX_GROUP >= 2.
module rlc_decomp
    import rlc_pkg::*;
#(
    parameter int MAX_GROUP = 10,
    localparam int CW = MAX_GROUP,
    localparam int GW = $clog2(MAX_GROUP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tst_toggle,
    input  logic tst_bit,
    output logic tst_ready,
    output logic scan_bit,
    output logic scan_valid
);

    logic          bit_stb;
    logic          run_at_one, run_low_zero, grp_last;
    logic          busy, one_out;
    logic [GW-1:0] grp_val;
    logic [CW-1:0] base_zeros;
    run_op_t       run_op;
    grp_op_t       grp_op;

    rlc_toggle_detect u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog    (tst_toggle),
        .strobe (bit_stb)
    );

    // Base zeros of group j: 2^j - 2.
    assign base_zeros = CW'(((CW+1)'(1) << grp_val) - (CW+1)'(2));

    rlc_run_counter #(.CW(CW)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (run_op),
        .load_val  (base_zeros),
        .shift_bit (tst_bit),
        .at_one    (run_at_one),
        .low_zero  (run_low_zero)
    );

    rlc_group_counter #(.MAX_GROUP(MAX_GROUP)) u_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (grp_op),
        .value (grp_val),
        .last  (grp_last)
    );

    rlc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (bit_stb),
        .code_bit     (tst_bit),
        .run_at_one   (run_at_one),
        .run_low_zero (run_low_zero),
        .grp_last     (grp_last),
        .run_op       (run_op),
        .grp_op       (grp_op),
        .busy         (busy),
        .one_out      (one_out)
    );

    assign tst_ready  = !busy;
    assign scan_valid = busy || one_out;
    assign scan_bit   = one_out;

endmodule

// File: rtl/rlc_decomp_chk.sv
// Property checker for rlc_decomp, attached by bind.
module rlc_decomp_chk (
    input logic clk,
    input logic rst_n,
    input logic tst_ready,
    input logic scan_valid,
    input logic scan_bit,
    input logic bit_stb
);

    // R4
    busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_ready |-> (scan_valid && !scan_bit));

    // R4
    zero_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_bit) |-> !tst_ready);

    // R8
    one_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_bit) |=> !(scan_valid && scan_bit));

    // R6
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_bit) |-> ($past(!tst_ready) || $past(bit_stb)));

endmodule

bind rlc_decomp rlc_decomp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tst_ready  (tst_ready),
    .scan_valid (scan_valid),
    .scan_bit   (scan_bit),
    .bit_stb    (bit_stb)
);

// File: tb/rlc_decomp_test.sv
module rlc_decomp_test;

    localparam int MAXG = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tst_toggle = 1'b0;
    logic tst_bit = 1'b0;
    logic tst_ready, scan_bit, scan_valid;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  prev_one = 1'b0;
    bit  exp_q[$];

    rlc_decomp #(.MAX_GROUP(MAXG)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tst_toggle (tst_toggle),
        .tst_bit    (tst_bit),
        .tst_ready  (tst_ready),
        .scan_bit   (scan_bit),
        .scan_valid (scan_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference comparison on every clock (R3, R4, R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (scan_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected output bit", 1, 0);
                end else begin
                    chk("R3 decoded bit", int'(scan_bit), int'(exp_q.pop_front()));
                end
            end
            chk("R4 ready vs zero emission", int'(tst_ready), int'(!(scan_valid && !scan_bit)));
            if (scan_valid && scan_bit && prev_one) chk("R8 consecutive ones", 1, 0);
            prev_one = scan_valid && scan_bit;
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send_bit(bit b, bit eager);
        if (!eager) begin
            @(negedge clk);
            repeat ($urandom_range(0, 1)) @(negedge clk);
        end
        while (!tst_ready) @(negedge clk);
        tst_bit    = b;
        tst_toggle = ~tst_toggle;
    endtask

    task automatic encode(int l, bit eager);
        int j = 1;
        int t;
        int n;
        while (l + 2 >= (1 << (j + 1))) j++;
        t = l - ((1 << j) - 2);
        for (int i = 0; i < l; i++) exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
        for (int i = 0; i < j - 1; i++) send_bit(1'b1, (i == 0) && eager);
        send_bit(1'b0, (j == 1) && eager);
        @(negedge clk);
        n = 0;
        while (!tst_ready) begin n++; @(negedge clk); end
        chk("R5 base zero burst length", n, (1 << j) - 2);
        for (int i = j - 1; i >= 0; i--) send_bit(t[i], i == j - 1);
        @(negedge clk);
        n = 0;
        while (!tst_ready) begin n++; @(negedge clk); end
        chk("R6 offset zero burst length", n, t);
        chk("R6 closing one follows burst", int'(scan_valid && scan_bit), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready during reset", int'(tst_ready), 1);
        chk("R1 valid during reset", int'(scan_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(tst_ready), 1);
        chk("R1 valid after reset", int'(scan_valid), 0);

        // R2: steady toggle, wiggling data: nothing happens.
        for (int i = 0; i < 20; i++) begin
            tst_bit = ~tst_bit;
            @(negedge clk);
            chk("R2 no output without toggle", int'(scan_valid), 0);
        end

        // R7: shortest codewords.
        encode(0, 1'b0);
        encode(1, 1'b0);
        // R3: first groups and boundaries.
        encode(2, 1'b0);
        encode(5, 1'b0);
        encode(6, 1'b0);
        encode(13, 1'b0);
        // R9: edges of the top group.
        encode((1 << MAXG) - 2, 1'b0);
        encode((1 << (MAXG + 1)) - 3, 1'b0);
        // R10: next codeword toggled in on the closing-one cycle.
        encode(3, 1'b1);
        encode(0, 1'b1);
        encode(0, 1'b1);
        encode(7, 1'b1);
        encode(1, 1'b1);

        // R3: random mix of run lengths and tester pacing.
        for (int k = 0; k < 150; k++) begin
            int l;
            if (k % 25 == 0) l = $urandom_range(100, (1 << (MAXG + 1)) - 3);
            else             l = $urandom_range(0, 40);
            encode(l, bit'($urandom_range(0, 1)));
        end

        repeat (5) @(negedge clk);
        chk("R3 all expected bits emitted", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule